// File: doc/BRIEF.md
# Port-Limited Operand Fetch Stage

This stage gathers the source operands of one shader instruction from a temporary register file that has fewer read ports than the three sources an instruction may name. Each instruction carries a source count (0 to 3), up to three source register indices and a destination index. The stage reads as many sources per cycle as it has read ports. When an instruction needs more reads than that, it spends extra cycles and holds off the upstream stage by dropping its ready signal until every source has been read.

A parameter picks two read ports or a single read port. Either way the file has one write port, which the writeback stage may use in any cycle, including cycles in which the same register is being read. In that case the new value goes straight to the reader. Once all sources are in hand, the stage presents the operand bundle, the destination index and the source count on registered outputs, together with a valid pulse that lasts one cycle.

Top module: `opnd_fetch_stage`

## Requirements
- R1: After reset, and until an instruction is accepted, in_ready is 1 and out_valid is 0. Asserting rst in the middle of a multi-cycle fetch returns the stage to this state, and no bundle is produced for the aborted instruction.
- R2: An instruction is accepted in a cycle where in_valid and in_ready are both 1. If its source count is no more than RD_PORTS, out_valid is 1 in the next cycle and in_ready stays 1, so such instructions can be accepted one per cycle.
- R3: With RD_PORTS=2, an instruction with source count 3 drops in_ready for exactly one cycle after acceptance, and out_valid is 1 two cycles after acceptance.
- R4: With RD_PORTS=1, a source count of 2 drops in_ready for one cycle and a source count of 3 drops it for two cycles. out_valid follows 2 or 3 cycles after acceptance. A source count of 0 or 1 needs no stall.
- R5: When out_valid is 1, out_op0, out_op1 and out_op2 hold the register values read for source slots 0, 1 and 2. Slot k is read only if k is less than the source count, and an unread slot reads 0. A source count of 0 gives a valid bundle of zeros one cycle after acceptance.
- R6: If the write port writes register r in the same cycle that a slot reads r, that slot receives the written data and not the old contents.
- R7: Slot k is read in cycle floor(k / RD_PORTS) after acceptance. A write landing in a stall cycle is therefore seen by slots read in that cycle or later, and not by slots read earlier. Written values persist for later instructions.
- R8: out_dst and out_nsrc equal the accepted instruction's destination index and source count whenever out_valid is 1.
- R9: An instruction offered while in_ready is 0 is not taken. It is accepted in the first cycle in_ready is 1 again, and it produces exactly one bundle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Upstream offers an instruction |
| in_ready | output | 1 | Stage can accept an instruction this cycle |
| in_nsrc | input | 2 | Number of sources used (0 to 3) |
| in_src0 | input | AW | Register index of source slot 0 |
| in_src1 | input | AW | Register index of source slot 1 |
| in_src2 | input | AW | Register index of source slot 2 |
| in_dst | input | AW | Destination register index |
| wr_en | input | 1 | Write port enable |
| wr_addr | input | AW | Write port register index |
| wr_data | input | DW | Write port data |
| out_valid | output | 1 | One-cycle pulse: operand bundle ready |
| out_nsrc | output | 2 | Source count of the bundle |
| out_dst | output | AW | Destination index of the bundle |
| out_op0 | output | DW | Operand for slot 0 |
| out_op1 | output | DW | Operand for slot 1 |
| out_op2 | output | DW | Operand for slot 2 |

## Verification
The bench runs a two-port and a one-port instance side by side. It measures the stall length and the bundle latency for every source count, so a sequencer that miscounts the read batches shows up as a bundle one cycle early or late, or with a missing stall. Writes are placed in the acceptance cycle and in a stall cycle. A design without the bypass would return stale data, and one that read the wrong batch in the wrong cycle would return old data where new is expected, or new where old is expected. The bench also checks that unread slots come back as zero, that an instruction held while stalled is taken once and only once, and that a reset in mid-fetch leaves no stray bundle.

// File: rtl/opf_pkg.sv
package opf_pkg;
  localparam int MAX_SRC = 3;
  localparam int CNT_W   = 2;
  typedef logic [CNT_W-1:0] slot_t;
endpackage

// File: rtl/opf_regfile.sv
module opf_regfile #(
  parameter int NREG = 16,
  parameter int DW   = 32,
  parameter int NRD  = 2,
  localparam int AW  = $clog2(NREG)
) (
  input  logic                    clk,
  input  logic                    wr_en,
  input  logic [AW-1:0]           wr_addr,
  input  logic [DW-1:0]           wr_data,
  input  logic [NRD-1:0][AW-1:0]  rd_addr,
  output logic [NRD-1:0][DW-1:0]  rd_data
);
  logic [DW-1:0] mem [NREG];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  // read ports with same-cycle write bypass
  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rd_data[p] = (wr_en && (wr_addr == rd_addr[p])) ? wr_data : mem[rd_addr[p]];
  end
endmodule

// File: rtl/opf_seq.sv
module opf_seq
  import opf_pkg::*;
#(
  parameter int RD_PORTS = 2
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  in_valid,
  input  slot_t in_nsrc,
  output logic  in_ready,
  output logic  accept,
  output logic  step,
  output logic  last,
  output slot_t base_slot,
  output slot_t cur_nsrc,
  output logic  out_valid
);
  logic  busy_q;
  slot_t slot_q;
  slot_t nsrc_q;

  assign in_ready  = !busy_q;
  assign accept    = in_valid && !busy_q;
  assign step      = accept || busy_q;
  assign cur_nsrc  = busy_q ? nsrc_q : in_nsrc;
  assign base_slot = busy_q ? slot_q : '0;
  assign last      = ({1'b0, base_slot} + 3'(RD_PORTS)) >= {1'b0, cur_nsrc};

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q    <= 1'b0;
      slot_q    <= '0;
      nsrc_q    <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= step && last;
      if (accept) nsrc_q <= in_nsrc;
      if (step) begin
        busy_q <= !last;
        slot_q <= base_slot + slot_t'(RD_PORTS);
      end
    end
  end
endmodule

// File: rtl/opf_collect.sv
module opf_collect
  import opf_pkg::*;
#(
  parameter int DW  = 32,
  parameter int NRD = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   accept,
  input  logic                   step,
  input  slot_t                  base_slot,
  input  slot_t                  cur_nsrc,
  input  logic [NRD-1:0][DW-1:0] rd_data,
  output logic [MAX_SRC-1:0][DW-1:0] ops
);
  for (genvar s = 0; s < MAX_SRC; s++) begin : g_slot
    logic          hit;
    logic [DW-1:0] sel;

    always_comb begin
      hit = 1'b0;
      sel = '0;
      for (int p = 0; p < NRD; p++) begin
        if (int'(base_slot) + p == s) begin
          sel = rd_data[p];
          hit = step && (s < int'(cur_nsrc));
        end
      end
    end

    always_ff @(posedge clk) begin
      if (rst)         ops[s] <= '0;
      else if (hit)    ops[s] <= sel;
      else if (accept) ops[s] <= '0;
    end
  end
endmodule

// File: rtl/opnd_fetch_stage.sv
module opnd_fetch_stage
  import opf_pkg::*;
#(
  parameter int RD_PORTS = 2,
  parameter int NREG     = 16,
  parameter int DW       = 32,
  localparam int AW      = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [1:0]    in_nsrc,
  input  logic [AW-1:0] in_src0,
  input  logic [AW-1:0] in_src1,
  input  logic [AW-1:0] in_src2,
  input  logic [AW-1:0] in_dst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic          out_valid,
  output logic [1:0]    out_nsrc,
  output logic [AW-1:0] out_dst,
  output logic [DW-1:0] out_op0,
  output logic [DW-1:0] out_op1,
  output logic [DW-1:0] out_op2
);
  logic  accept, step, last;
  slot_t base_slot, cur_nsrc;

  logic [MAX_SRC-1:0][AW-1:0] src_in, src_q;
  logic [AW-1:0]              dst_q;
  logic [RD_PORTS-1:0][AW-1:0] rd_addr;
  logic [RD_PORTS-1:0][DW-1:0] rd_data;
  logic [MAX_SRC-1:0][DW-1:0]  ops;

  assign src_in[0] = in_src0;
  assign src_in[1] = in_src1;
  assign src_in[2] = in_src2;

  opf_seq #(.RD_PORTS(RD_PORTS)) u_seq (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_nsrc(in_nsrc),
    .in_ready(in_ready), .accept(accept), .step(step), .last(last),
    .base_slot(base_slot), .cur_nsrc(cur_nsrc), .out_valid(out_valid)
  );

  // held copy of the instruction for stall cycles
  always_ff @(posedge clk) begin
    if (rst) begin
      src_q <= '0;
      dst_q <= '0;
    end else if (accept) begin
      src_q <= src_in;
      dst_q <= in_dst;
    end
  end

  // read address per port: slot = base + port
  for (genvar p = 0; p < RD_PORTS; p++) begin : g_addr
    always_comb begin
      rd_addr[p] = '0;
      for (int s = 0; s < MAX_SRC; s++) begin
        if (int'(base_slot) + p == s)
          rd_addr[p] = in_ready ? src_in[s] : src_q[s];
      end
    end
  end

  opf_regfile #(.NREG(NREG), .DW(DW), .NRD(RD_PORTS)) u_rf (
    .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  opf_collect #(.DW(DW), .NRD(RD_PORTS)) u_col (
    .clk(clk), .rst(rst), .accept(accept), .step(step),
    .base_slot(base_slot), .cur_nsrc(cur_nsrc), .rd_data(rd_data), .ops(ops)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_dst  <= '0;
      out_nsrc <= '0;
    end else if (step && last) begin
      out_dst  <= in_ready ? in_dst : dst_q;
      out_nsrc <= cur_nsrc;
    end
  end

  assign out_op0 = ops[0];
  assign out_op1 = ops[1];
  assign out_op2 = ops[2];
endmodule

// File: rtl/opf_checker.sv
module opf_checker #(
  parameter int RD_PORTS = 2,
  parameter int DW       = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic          in_ready,
  input logic [1:0]    in_nsrc,
  input logic          out_valid,
  input logic [1:0]    out_nsrc,
  input logic [DW-1:0] out_op1,
  input logic [DW-1:0] out_op2
);
  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (in_ready && !out_valid));

  p_short_latency_r2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && (int'(in_nsrc) <= RD_PORTS)) |=> (out_valid && in_ready));

  p_long_stalls_r3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && (int'(in_nsrc) > RD_PORTS)) |=> (!in_ready && !out_valid));

  p_one_port_two_stalls_r4: assert property (@(posedge clk) disable iff (rst)
    (RD_PORTS == 1 && in_valid && in_ready && in_nsrc == 2'd3) |=> !in_ready ##1 !in_ready);

  p_no_bundle_at_stall_start_r9: assert property (@(posedge clk) disable iff (rst)
    $fell(in_ready) |-> !out_valid);

  p_unused_slot1_zero_r5: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_nsrc < 2'd2) |-> (out_op1 == '0));

  p_unused_slot2_zero_r5: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_nsrc < 2'd3) |-> (out_op2 == '0));
endmodule

bind opnd_fetch_stage opf_checker #(.RD_PORTS(RD_PORTS), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .in_nsrc(in_nsrc), .out_valid(out_valid), .out_nsrc(out_nsrc),
  .out_op1(out_op1), .out_op2(out_op2)
);

// File: tb/opnd_fetch_stage_test.sv
module opnd_fetch_stage_test;
  localparam int AW = 4;
  localparam int DW = 32;
  localparam int NV = 8;
  // {nsrc[1:0], src0, src1, src2, dst}
  localparam logic [17:0] VEC [NV] = '{
    {2'd1, 4'd3,  4'd0,  4'd0,  4'd9},
    {2'd2, 4'd4,  4'd11, 4'd8,  4'd2},
    {2'd3, 4'd1,  4'd2,  4'd15, 4'd7},
    {2'd0, 4'd6,  4'd5,  4'd4,  4'd5},
    {2'd3, 4'd6,  4'd6,  4'd6,  4'd1},
    {2'd2, 4'd0,  4'd15, 4'd3,  4'd14},
    {2'd1, 4'd15, 4'd2,  4'd1,  4'd0},
    {2'd3, 4'd12, 4'd13, 4'd14, 4'd3}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [1:0] in_nsrc = '0;
  logic [AW-1:0] in_src0 = '0, in_src1 = '0, in_src2 = '0, in_dst = '0;
  logic wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;

  logic rdy2, ov2, rdy1, ov1;
  logic [1:0] ns2, ns1;
  logic [AW-1:0] dst2, dst1;
  logic [DW-1:0] a0, a1, a2, b0, b1, b2;

  int nchk = 0;
  int nfail = 0;
  int cyc = 0;
  logic [DW-1:0] model [16];

  always #4 clk = ~clk;

  opnd_fetch_stage #(.RD_PORTS(2)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(rdy2), .in_nsrc(in_nsrc),
    .in_src0(in_src0), .in_src1(in_src1), .in_src2(in_src2), .in_dst(in_dst),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .out_valid(ov2), .out_nsrc(ns2), .out_dst(dst2), .out_op0(a0), .out_op1(a1), .out_op2(a2)
  );

  opnd_fetch_stage #(.RD_PORTS(1)) uut_p1 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(rdy1), .in_nsrc(in_nsrc),
    .in_src0(in_src0), .in_src1(in_src1), .in_src2(in_src2), .in_dst(in_dst),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .out_valid(ov1), .out_nsrc(ns1), .out_dst(dst1), .out_op0(b0), .out_op1(b1), .out_op2(b2)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      nfail++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      summary();
    end
  end

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    model[a] = d;
  endtask

  // expected value of slot s for a port count, given writes at cycle 0 and 1
  function automatic logic [DW-1:0] expv(int ports, int s, int n, logic [AW-1:0] src,
      logic w0e, logic [AW-1:0] w0a, logic [DW-1:0] w0d,
      logic w1e, logic [AW-1:0] w1a, logic [DW-1:0] w1d);
    logic [DW-1:0] v;
    if (s >= n) return '0;
    v = model[src];
    if (w0e && w0a == src) v = w0d;
    if (w1e && w1a == src && (s / ports) >= 1) v = w1d;
    return v;
  endfunction

  task automatic issue(input logic [1:0] n, input logic [AW-1:0] s0, s1, s2, d,
      input logic w0e, input logic [AW-1:0] w0a, input logic [DW-1:0] w0d,
      input logic w1e, input logic [AW-1:0] w1a, input logic [DW-1:0] w1d);
    int lat2 = 0, lat1 = 0, st2 = 0, st1 = 0;
    logic [DW-1:0] g2 [3];
    logic [DW-1:0] g1 [3];
    logic [1:0] gn2 = '0, gn1 = '0;
    logic [AW-1:0] gd2 = '0, gd1 = '0;
    logic [AW-1:0] sv [3];
    int e2, e1;
    string lt1;
    sv[0] = s0; sv[1] = s1; sv[2] = s2;
    for (int k = 0; k < 3; k++) begin g2[k] = 'x; g1[k] = 'x; end
    @(negedge clk);
    in_valid = 1'b1; in_nsrc = n; in_src0 = s0; in_src1 = s1; in_src2 = s2; in_dst = d;
    wr_en = w0e; wr_addr = w0a; wr_data = w0d;
    for (int c = 1; c <= 4; c++) begin
      @(negedge clk);
      if (c == 1) begin
        in_valid = 1'b0;
        wr_en = w1e; wr_addr = w1a; wr_data = w1d;
      end else begin
        wr_en = 1'b0;
      end
      if (ov2 && lat2 == 0) begin lat2 = c; g2[0] = a0; g2[1] = a1; g2[2] = a2; gn2 = ns2; gd2 = dst2; end
      if (ov1 && lat1 == 0) begin lat1 = c; g1[0] = b0; g1[1] = b1; g1[2] = b2; gn1 = ns1; gd1 = dst1; end
      if (!rdy2) st2++;
      if (!rdy1) st1++;
    end
    e2 = (n == 0) ? 1 : (int'(n) + 1) / 2;
    e1 = (n == 0) ? 1 : int'(n);
    lt1 = (n >= 2) ? "R4 p1 latency" : "R2 p1 latency";
    chk(n == 3 ? "R3 p2 latency" : "R2 p2 latency", lat2, e2);
    chk(n == 3 ? "R3 p2 stalls" : "R2 p2 stalls", st2, e2 - 1);
    chk(lt1, lat1, e1);
    chk("R4 p1 stalls", st1, e1 - 1);
    for (int k = 0; k < 3; k++) begin
      chk("R5/R6/R7 p2 operand", g2[k], expv(2, k, n, sv[k], w0e, w0a, w0d, w1e, w1a, w1d));
      chk("R5/R6/R7 p1 operand", g1[k], expv(1, k, n, sv[k], w0e, w0a, w0d, w1e, w1a, w1d));
    end
    chk("R8 p2 dst", gd2, d);
    chk("R8 p2 nsrc", gn2, n);
    chk("R8 p1 dst", gd1, d);
    chk("R8 p1 nsrc", gn1, n);
    if (w0e) model[w0a] = w0d;
    if (w1e) model[w1a] = w1d;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 p2 ready", rdy2, 1'b1);
    chk("R1 p2 valid", ov2, 1'b0);
    chk("R1 p1 ready", rdy1, 1'b1);
    chk("R1 p1 valid", ov1, 1'b0);

    for (int r = 0; r < 16; r++) wr(AW'(r), 32'h1000_0000 + r * 32'h0101_0101);

    // table walk
    for (int i = 0; i < NV; i++) begin
      issue(VEC[i][17:16], VEC[i][15:12], VEC[i][11:8], VEC[i][7:4], VEC[i][3:0],
            1'b0, '0, '0, 1'b0, '0, '0);
    end

    // R6: write in acceptance cycle to a register being read
    issue(2'd1, 4'd5, 4'd0, 4'd0, 4'd4, 1'b1, 4'd5, 32'hDEAD_BEEF, 1'b0, '0, '0);
    // R7: write in the first stall cycle to the slot-1 register
    issue(2'd2, 4'd9, 4'd7, 4'd0, 4'd6, 1'b0, '0, '0, 1'b1, 4'd7, 32'h1234_5678);
    // R7: write in the stall cycle to the slot-2 register
    issue(2'd3, 4'd1, 4'd2, 4'd9, 4'd8, 1'b0, '0, '0, 1'b1, 4'd9, 32'hCAFE_0009);
    // R7: persisted values read back
    issue(2'd3, 4'd7, 4'd9, 4'd5, 4'd10, 1'b0, '0, '0, 1'b0, '0, '0);

    // R9: instruction held through a stall on the two-port instance
    @(negedge clk);
    in_valid = 1'b1; in_nsrc = 2'd3; in_src0 = 4'd1; in_src1 = 4'd2; in_src2 = 4'd3; in_dst = 4'd11;
    @(negedge clk);
    chk("R9 stall ready", rdy2, 1'b0);
    in_nsrc = 2'd1; in_src0 = 4'd4; in_dst = 4'd12;
    @(negedge clk);
    chk("R9 first bundle valid", ov2, 1'b1);
    chk("R9 first bundle dst", dst2, 4'd11);
    chk("R9 ready again", rdy2, 1'b1);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R9 held bundle valid", ov2, 1'b1);
    chk("R9 held bundle dst", dst2, 4'd12);
    chk("R9 held bundle op", a0, model[4]);
    @(negedge clk);
    chk("R9 no duplicate", ov2, 1'b0);
    repeat (4) @(negedge clk);

    // R2: back-to-back single-source instructions
    in_valid = 1'b1; in_nsrc = 2'd1; in_src0 = 4'd13; in_dst = 4'd1;
    @(negedge clk);
    chk("R2 b2b ready", rdy2, 1'b1);
    chk("R2 b2b first", {ov2, dst2}, {1'b1, 4'd1});
    in_src0 = 4'd14; in_dst = 4'd2;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R2 b2b second", {ov2, dst2}, {1'b1, 4'd2});
    chk("R2 b2b second op", a0, model[14]);
    repeat (4) @(negedge clk);

    // R1: reset during a stall
    in_valid = 1'b1; in_nsrc = 2'd3; in_src0 = 4'd1; in_src1 = 4'd2; in_src2 = 4'd3; in_dst = 4'd4;
    @(negedge clk);
    in_valid = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R1 mid reset p2 ready", rdy2, 1'b1);
    chk("R1 mid reset p1 ready", rdy1, 1'b1);
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      chk("R1 mid reset p2 no bundle", ov2, 1'b0);
      chk("R1 mid reset p1 no bundle", ov1, 1'b0);
    end
    summary();
  end
endmodule